// File: doc/BRIEF.md
# Page Walk Permission Checker

This block sits beside a page-table walker and judges one address translation at a time. The walker announces a new walk with a start strobe and supplies the attributes of the access. These are the access kind, the privilege level, the paging mode and the no-execute enable. The walker then hands over the paging-structure entries one per cycle, from the top level down. Each entry reports its present, writable, user-accessible, execute-disable and reserved-bit-violation flags.

The checker folds the entry flags across levels. The writable and user flags combine by AND and the execute-disable flag combines by OR. The walk stops at the last entry, or earlier at the first entry that is absent or that violates a reserved bit. One cycle later the block reports whether the access is allowed or faults. On a fault it also gives the page-fault vector number and an error code. The error code separates a missing translation from a rights violation, and it records the kind of access and the privilege level.

Top module: `pgwalk_perm_check`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `res_valid`, `res_fault`, `res_vector` and `res_err` are all zero.
- R2: When the entry flagged `ent_last` is accepted, `res_valid` is high for exactly one cycle, on the cycle after that entry. No other accepted entry in a walk without early termination produces a result.
- R3: An accepted entry with `ent_present`=0 ends the walk at once and gives a fault with error code bit 0 = 0 and bit 3 = 0, even if its reserved flag is set. Later entries produce no result until the next `walk_start`.
- R4: A present entry with `ent_rsvd`=1 ends the walk at once and gives a fault with error code bit 0 = 1 and bit 3 = 1.
- R5: A user write (acc_type 1, cpl 3) is allowed only if every entry has both `ent_rw`=1 and `ent_us`=1. Otherwise it faults with error code bit 0 = 1.
- R6: A user read (acc_type 0, cpl 3) is allowed only if every entry has `ent_us`=1.
- R7: A supervisor read or write (cpl 0, 1 or 2) with a valid translation is allowed whatever the writable and user flags are.
- R8: With pg_mode 0 (32-bit) or `nxe`=0, execute-disable has no effect on a fetch (acc_type 2). A user fetch then needs only `ent_us`=1 in every entry, and error code bit 4 stays 0.
- R9: With pg_mode 1 (PAE) or 2 (64-bit) and `nxe`=1, a fetch at any privilege faults if any entry has `ent_xd`=1. A user fetch also needs `ent_us`=1 throughout. Every fetch fault in this setting sets error code bit 4.
- R10: On a fault, `res_vector` is 14, error code bit 1 equals "access is a write" and bit 2 equals "cpl is 3". On an allowed access, `res_vector` and `res_err` are zero.
- R11: `walk_start` clears all folded flags and restarts the walk, even in the middle of one. An entry presented while no walk is open, or in the same cycle as `walk_start`, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| walk_start | input | 1 | Opens a new walk and captures the access attributes |
| acc_type | input | 2 | Access kind: 0 read, 1 write, 2 instruction fetch |
| cpl | input | 2 | Privilege level; 3 is user |
| pg_mode | input | 2 | Paging mode: 0 32-bit, 1 PAE, 2 64-bit |
| nxe | input | 1 | No-execute enable |
| ent_valid | input | 1 | An entry is presented this cycle |
| ent_last | input | 1 | This entry is the final level |
| ent_present | input | 1 | Entry present flag |
| ent_rw | input | 1 | Entry writable flag |
| ent_us | input | 1 | Entry user-accessible flag |
| ent_xd | input | 1 | Entry execute-disable flag |
| ent_rsvd | input | 1 | Entry sets a reserved bit |
| res_valid | output | 1 | One-cycle result strobe |
| res_fault | output | 1 | 1 when the access faults |
| res_vector | output | 8 | Exception vector (14 on fault) |
| res_err | output | 16 | Error code: bit0 present, bit1 write, bit2 user, bit3 reserved, bit4 fetch |

## Verification
The bench places a single offending flag at a middle level of the walk, so a design that checks only the leaf entry would allow the access. It also sends an entry that is absent and has its reserved flag set. A design that lets the reserved flag win would report bit 0 as 1 and set bit 3. After an early stop the walker keeps sending entries, and a design that does not close the walk would produce a second strobe. Execute-disable is set in 32-bit mode and again with `nxe` off, and a design that ignores the mode would fault those fetches. A restart arrives after a denying entry, and a design that keeps its folded flags would deny the next clean walk.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef enum logic [1:0] {
    PG_32   = 2'd0,
    PG_PAE  = 2'd1,
    PG_LONG = 2'd2
  } pgmode_e;

  // Attributes captured at walk start
  typedef struct packed {
    acc_e acc;
    logic user;
    logic nx_act;
  } attr_t;

  localparam int unsigned EC_BITS = 5;
  localparam int unsigned EC_P    = 0;
  localparam int unsigned EC_W    = 1;
  localparam int unsigned EC_U    = 2;
  localparam int unsigned EC_RSV  = 3;
  localparam int unsigned EC_ID   = 4;

  // Execute-disable is honoured only outside 32-bit mode with nxe set
  function automatic logic nx_active(pgmode_e mode, logic nxe);
    return nxe && (mode != PG_32);
  endfunction

  // Rights check over the folded flags of a valid translation
  function automatic logic rights_ok(attr_t a, logic rw_all, logic us_all,
                                     logic xd_any);
    logic ok;
    ok = 1'b1;
    if (a.acc == ACC_FETCH && a.nx_act && xd_any) ok = 1'b0;
    if (a.user && !us_all) ok = 1'b0;
    if (a.user && a.acc == ACC_WRITE && !rw_all) ok = 1'b0;
    return ok;
  endfunction

  // Error code for a fault
  function automatic logic [EC_BITS-1:0] build_err(attr_t a, logic no_xlate,
                                                   logic rsv_fault);
    logic [EC_BITS-1:0] e;
    e          = '0;
    e[EC_P]    = !no_xlate;
    e[EC_W]    = (a.acc == ACC_WRITE);
    e[EC_U]    = a.user;
    e[EC_RSV]  = rsv_fault;
    e[EC_ID]   = (a.acc == ACC_FETCH) && a.nx_act;
    return e;
  endfunction

endpackage

// File: rtl/pwc_walk_ctrl.sv
module pwc_walk_ctrl
  import pwc_pkg::*;
#(
  parameter int unsigned CPL_W    = 2,
  parameter int unsigned USER_CPL = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             walk_start,
  input  logic [1:0]       acc_type,
  input  logic [CPL_W-1:0] cpl,
  input  logic [1:0]       pg_mode,
  input  logic             nxe,
  input  logic             ent_valid,
  input  logic             ent_last,
  input  logic             ent_present,
  input  logic             ent_rsvd,
  output logic             busy,
  output logic             ent_accept,
  output logic             walk_done,
  output attr_t            attr_q
);

  localparam logic [CPL_W-1:0] USER_LVL = CPL_W'(USER_CPL);

  attr_t attr_d;

  always_comb begin
    attr_d.acc    = acc_e'(acc_type);
    attr_d.user   = (cpl == USER_LVL);
    attr_d.nx_act = nx_active(pgmode_e'(pg_mode), nxe);
  end

  // Start has priority; an entry in the start cycle is dropped
  assign ent_accept = busy && ent_valid && !walk_start;
  assign walk_done  = ent_accept && (ent_last || !ent_present || ent_rsvd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      attr_q <= '0;
    end else if (walk_start) begin
      busy   <= 1'b1;
      attr_q <= attr_d;
    end else if (walk_done) begin
      busy   <= 1'b0;
    end
  end

endmodule

// File: rtl/pwc_flag_accum.sv
module pwc_flag_accum (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic accept,
  input  logic ent_rw,
  input  logic ent_us,
  input  logic ent_xd,
  output logic rw_all,
  output logic us_all,
  output logic xd_any
);

  logic rw_q, us_q, xd_q;

  // Folded values including the entry on the inputs now
  assign rw_all = rw_q & ent_rw;
  assign us_all = us_q & ent_us;
  assign xd_any = xd_q | ent_xd;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      rw_q <= 1'b1;
      us_q <= 1'b1;
      xd_q <= 1'b0;
    end else if (accept) begin
      rw_q <= rw_all;
      us_q <= us_all;
      xd_q <= xd_any;
    end
  end

endmodule

// File: rtl/pwc_decide.sv
module pwc_decide
  import pwc_pkg::*;
(
  input  attr_t              attr,
  input  logic               ent_present,
  input  logic               ent_rsvd,
  input  logic               rw_all,
  input  logic               us_all,
  input  logic               xd_any,
  output logic               no_xlate,
  output logic               rsv_fault,
  output logic               rights_fault,
  output logic               fault,
  output logic [EC_BITS-1:0] code
);

  // Absence outranks a reserved-bit violation on the same entry
  assign no_xlate     = !ent_present;
  assign rsv_fault    = ent_present && ent_rsvd;
  assign rights_fault = !rights_ok(attr, rw_all, us_all, xd_any);
  assign fault        = no_xlate || rsv_fault || rights_fault;
  assign code         = build_err(attr, no_xlate, rsv_fault);

endmodule

// File: rtl/pgwalk_perm_check.sv
module pgwalk_perm_check
  import pwc_pkg::*;
#(
  parameter int unsigned ERR_W     = 16,
  parameter int unsigned VEC_W     = 8,
  parameter int unsigned PF_VECTOR = 14,
  parameter int unsigned CPL_W     = 2,
  parameter int unsigned USER_CPL  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             walk_start,
  input  logic [1:0]       acc_type,
  input  logic [CPL_W-1:0] cpl,
  input  logic [1:0]       pg_mode,
  input  logic             nxe,
  input  logic             ent_valid,
  input  logic             ent_last,
  input  logic             ent_present,
  input  logic             ent_rw,
  input  logic             ent_us,
  input  logic             ent_xd,
  input  logic             ent_rsvd,
  output logic             res_valid,
  output logic             res_fault,
  output logic [VEC_W-1:0] res_vector,
  output logic [ERR_W-1:0] res_err
);

  localparam int unsigned ERR_PAD = ERR_W - EC_BITS;
  localparam logic [VEC_W-1:0] PF_VEC = VEC_W'(PF_VECTOR);

  // Named internal events
  logic               busy;
  logic               ent_accept;
  logic               walk_done;
  attr_t              attr_q;
  logic               rw_all, us_all, xd_any;
  logic               no_xlate, rsv_fault, rights_fault, fault;
  logic [EC_BITS-1:0] code;
  logic               attr_is_write;
  logic               attr_is_user;

  assign attr_is_write = (attr_q.acc == ACC_WRITE);
  assign attr_is_user  = attr_q.user;

  pwc_walk_ctrl #(.CPL_W(CPL_W), .USER_CPL(USER_CPL)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .walk_start (walk_start),
    .acc_type   (acc_type),
    .cpl        (cpl),
    .pg_mode    (pg_mode),
    .nxe        (nxe),
    .ent_valid  (ent_valid),
    .ent_last   (ent_last),
    .ent_present(ent_present),
    .ent_rsvd   (ent_rsvd),
    .busy       (busy),
    .ent_accept (ent_accept),
    .walk_done  (walk_done),
    .attr_q     (attr_q)
  );

  pwc_flag_accum u_accum (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (walk_start),
    .accept(ent_accept),
    .ent_rw(ent_rw),
    .ent_us(ent_us),
    .ent_xd(ent_xd),
    .rw_all(rw_all),
    .us_all(us_all),
    .xd_any(xd_any)
  );

  pwc_decide u_decide (
    .attr        (attr_q),
    .ent_present (ent_present),
    .ent_rsvd    (ent_rsvd),
    .rw_all      (rw_all),
    .us_all      (us_all),
    .xd_any      (xd_any),
    .no_xlate    (no_xlate),
    .rsv_fault   (rsv_fault),
    .rights_fault(rights_fault),
    .fault       (fault),
    .code        (code)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_fault  <= 1'b0;
      res_vector <= '0;
      res_err    <= '0;
    end else begin
      res_valid <= walk_done;
      if (walk_done) begin
        res_fault  <= fault;
        res_vector <= fault ? PF_VEC : '0;
        res_err    <= fault ? {{ERR_PAD{1'b0}}, code} : '0;
      end
    end
  end

endmodule

// File: rtl/pwc_checker.sv
module pwc_checker #(
  parameter int unsigned ERR_W     = 16,
  parameter int unsigned VEC_W     = 8,
  parameter int unsigned PF_VECTOR = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             ent_valid,
  input logic             walk_done,
  input logic             attr_is_write,
  input logic             attr_is_user,
  input logic             res_valid,
  input logic             res_fault,
  input logic [VEC_W-1:0] res_vector,
  input logic [ERR_W-1:0] res_err
);

  assert_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  assert_done_to_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |=> res_valid);

  assert_valid_from_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(walk_done));

  assert_rsvd_present_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_err[3]) |-> res_err[0]);

  assert_vector_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault) |-> (res_vector == VEC_W'(PF_VECTOR)));

  assert_allow_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_fault) |-> (res_err == '0 && res_vector == '0));

  assert_write_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault) |-> (res_err[1] == $past(attr_is_write)));

  assert_user_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault) |-> (res_err[2] == $past(attr_is_user)));

  assert_idle_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ent_valid) |=> !res_valid);

endmodule

bind pgwalk_perm_check pwc_checker #(
  .ERR_W(ERR_W), .VEC_W(VEC_W), .PF_VECTOR(PF_VECTOR)
) u_pwc_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .ent_valid    (ent_valid),
  .walk_done    (walk_done),
  .attr_is_write(attr_is_write),
  .attr_is_user (attr_is_user),
  .res_valid    (res_valid),
  .res_fault    (res_fault),
  .res_vector   (res_vector),
  .res_err      (res_err)
);

// File: tb/pgwalk_perm_check_test.sv
module pgwalk_perm_check_test;

  typedef logic [4:0] lvl_t [0:4];   // per level {present, rw, us, xd, rsvd}

  localparam logic [4:0] FP = 5'b10000, FW = 5'b01000, FU = 5'b00100,
                         FX = 5'b00010, FR = 5'b00001;
  localparam logic [4:0] G  = FP | FW | FU;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, walk_start, nxe;
  logic [1:0]  acc_type, cpl, pg_mode;
  logic        ent_valid, ent_last, ent_present, ent_rw, ent_us, ent_xd, ent_rsvd;
  logic        res_valid, res_fault;
  logic [7:0]  res_vector;
  logic [15:0] res_err;

  int n_run  = 0;
  int n_fail = 0;

  pgwalk_perm_check uut (
    .clk(clk), .rst_n(rst_n), .walk_start(walk_start), .acc_type(acc_type),
    .cpl(cpl), .pg_mode(pg_mode), .nxe(nxe), .ent_valid(ent_valid),
    .ent_last(ent_last), .ent_present(ent_present), .ent_rw(ent_rw),
    .ent_us(ent_us), .ent_xd(ent_xd), .ent_rsvd(ent_rsvd),
    .res_valid(res_valid), .res_fault(res_fault), .res_vector(res_vector),
    .res_err(res_err)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  // Reference: walk levels in order, stop at the first broken one
  function automatic logic [5:0] model(logic [1:0] acc, logic [1:0] pl,
                                       logic [1:0] mode, logic nx, int n,
                                       lvl_t lv, output int stop_at);
    bit missing = 0, badrsv = 0, stopped = 0;
    bit wr_ok = 1, us_ok = 1, xd_seen = 0;
    bit user = (pl == 2'd3);
    bit nx_on = nx && (mode != 2'd0);
    bit deny, flt;
    logic [4:0] ec;
    stop_at = n - 1;
    for (int i = 0; i < n; i++) begin
      if (!stopped) begin
        if (!lv[i][4]) begin missing = 1; stopped = 1; stop_at = i; end
        else if (lv[i][0]) begin badrsv = 1; stopped = 1; stop_at = i; end
        else begin
          if (!lv[i][3]) wr_ok = 0;
          if (!lv[i][2]) us_ok = 0;
          if (lv[i][1]) xd_seen = 1;
        end
      end
    end
    deny = (user && !us_ok) || (user && acc == 2'd1 && !wr_ok) ||
           (acc == 2'd2 && nx_on && xd_seen);
    flt = missing || badrsv || deny;
    ec = 5'd0;
    if (flt) ec = {acc == 2'd2 && nx_on, badrsv, user, acc == 2'd1, !missing};
    return {flt, ec};
  endfunction

  task automatic open_walk(logic [1:0] acc, logic [1:0] pl, logic [1:0] mode,
                           logic nx);
    @(negedge clk);
    acc_type = acc; cpl = pl; pg_mode = mode; nxe = nx;
    walk_start = 1'b1; ent_valid = 1'b0;
    @(posedge clk); #1;
    walk_start = 1'b0;
  endtask

  task automatic put_entry(logic [4:0] e, logic last);
    @(negedge clk);
    ent_valid = 1'b1; ent_last = last;
    {ent_present, ent_rw, ent_us, ent_xd, ent_rsvd} = e;
    @(posedge clk); #1;
  endtask

  task automatic run_walk(string tag, logic [1:0] acc, logic [1:0] pl,
                          logic [1:0] mode, logic nx, int n, lvl_t lv);
    int stop_at;
    logic [5:0] exp;
    exp = model(acc, pl, mode, nx, n, lv, stop_at);
    open_walk(acc, pl, mode, nx);
    for (int i = 0; i < n; i++) begin
      put_entry(lv[i], i == n - 1);
      if (i == stop_at) begin
        chk({tag, " valid"}, res_valid, 1);
        chk({tag, " fault"}, res_fault, exp[5]);
        chk({tag, " vector"}, res_vector, exp[5] ? 14 : 0);
        chk({tag, " errcode"}, res_err, {27'd0, exp[4:0]});
      end else begin
        chk({tag, " no early/extra strobe"}, res_valid, 0);
      end
    end
    @(negedge clk); ent_valid = 1'b0; ent_last = 1'b0;
    @(posedge clk); #1;
    chk({tag, " strobe one cycle"}, res_valid, 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; walk_start = 0; ent_valid = 0; ent_last = 0;
    acc_type = 0; cpl = 0; pg_mode = 0; nxe = 0;
    {ent_present, ent_rw, ent_us, ent_xd, ent_rsvd} = 5'd0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 valid in reset", res_valid, 0);
    chk("R1 errcode in reset", res_err, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 valid after reset", res_valid, 0);
    chk("R1 fault after reset", res_fault, 0);
    chk("R1 vector after reset", res_vector, 0);
  endtask

  task automatic t_idle_entry;
    put_entry(FR, 1'b1);   // absent, last, but no walk open
    chk("R11 idle entry ignored", res_valid, 0);
    @(negedge clk); ent_valid = 0; ent_last = 0;
    @(posedge clk); #1;
    chk("R11 idle entry no late strobe", res_valid, 0);
  endtask

  task automatic t_user_write;
    run_walk("R2 R5 user write clean", 2'd1, 2'd3, 2'd2, 1'b0, 4, '{G, G, G, G, G});
    run_walk("R5 user write ro mid", 2'd1, 2'd3, 2'd2, 1'b0, 4, '{G, G, FP|FU, G, G});
  endtask

  task automatic t_user_read;
    run_walk("R6 user read us0 mid", 2'd0, 2'd3, 2'd1, 1'b0, 4, '{G, FP|FW, G, G, G});
    run_walk("R6 user read ro ok", 2'd0, 2'd3, 2'd1, 1'b0, 3, '{FP|FU, FP|FU, FP|FU, G, G});
  endtask

  task automatic t_supervisor;
    run_walk("R7 sup write no rw us", 2'd1, 2'd0, 2'd2, 1'b1, 4, '{FP, FP, FP, FP, G});
    run_walk("R7 sup read no rw us", 2'd0, 2'd2, 2'd0, 1'b0, 2, '{FP, FP, G, G, G});
  endtask

  task automatic t_not_present;
    run_walk("R3 absent with rsvd", 2'd0, 2'd3, 2'd2, 1'b0, 4, '{G, FR, G, G, G});
    run_walk("R3 absent first sup write", 2'd1, 2'd0, 2'd1, 1'b0, 3, '{5'd0, G, G, G, G});
  endtask

  task automatic t_reserved;
    run_walk("R4 rsvd present", 2'd1, 2'd0, 2'd2, 1'b0, 4, '{G, G, G|FR, G, G});
  endtask

  task automatic t_fetch_legacy;
    run_walk("R8 fetch 32bit xd ignored", 2'd2, 2'd3, 2'd0, 1'b1, 2, '{G|FX, G|FX, G, G, G});
    run_walk("R8 fetch pae nxe0 xd ignored", 2'd2, 2'd3, 2'd1, 1'b0, 3, '{G, G|FX, G, G, G});
    run_walk("R8 fetch 32bit us0", 2'd2, 2'd3, 2'd0, 1'b0, 2, '{G, FP|FW, G, G, G});
  endtask

  task automatic t_fetch_nx;
    run_walk("R9 user fetch xd long", 2'd2, 2'd3, 2'd2, 1'b1, 4, '{G, G, G|FX, G, G});
    run_walk("R9 sup fetch xd pae", 2'd2, 2'd0, 2'd1, 1'b1, 3, '{G|FX, G, G, G, G});
    run_walk("R9 user fetch us0 long", 2'd2, 2'd3, 2'd2, 1'b1, 4, '{G, G, G, FP|FW, G});
    run_walk("R9 R10 user fetch allowed", 2'd2, 2'd3, 2'd2, 1'b1, 4, '{G, G, G, G, G});
  endtask

  task automatic t_restart;
    open_walk(2'd1, 2'd3, 2'd2, 1'b0);
    put_entry(FP|FU, 1'b0);            // denying entry, walk left open
    chk("R11 no strobe mid walk", res_valid, 0);
    run_walk("R11 restart clears flags", 2'd1, 2'd3, 2'd2, 1'b0, 2, '{G, G, G, G, G});
    // entry presented in the same cycle as start is dropped
    @(negedge clk);
    acc_type = 2'd0; cpl = 2'd3; pg_mode = 2'd2; nxe = 0;
    walk_start = 1'b1; ent_valid = 1'b1; ent_last = 1'b1;
    {ent_present, ent_rw, ent_us, ent_xd, ent_rsvd} = 5'd0;
    @(posedge clk); #1;
    walk_start = 1'b0;
    put_entry(G, 1'b1);
    chk("R11 start-cycle entry dropped valid", res_valid, 1);
    chk("R11 start-cycle entry dropped fault", res_fault, 0);
    @(negedge clk); ent_valid = 0; ent_last = 0;
    @(posedge clk); #1;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_idle_entry();
    t_user_write();
    t_user_read();
    t_supervisor();
    t_not_present();
    t_reserved();
    t_fetch_legacy();
    t_fetch_nx();
    t_restart();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule